// File: doc/BRIEF.md
# Debug Monitor Mode Entry Controller

This block decides, once per power-on, whether the chip starts in its debug monitor mode, and which route brought it there. When the reset sequence ends, it samples these inputs:

- a high-voltage flag on the interrupt pin;
- a divisor strap pin;
- a flag that says the reset vector is erased.

From that sample it latches the mode and the entry route. The latched result then drives four things: the bus-clock divide ratio, a clock-enable pulse train at that ratio, a flag that bypasses the oscillator's divide-by-two stage, and the watchdog-disable output.

There are two entry routes. The high-voltage route wins whenever the interrupt pin is at high voltage. On this route the strap picks divide-by-two (with the oscillator stage bypassed) or divide-by-four. The watchdog stays off only while high voltage is present on the interrupt pin or the reset pin, so the voltage can be moved to the reset pin after entry. The erased-vector route ignores the strap and uses divide-by-four. It keeps the watchdog off for the whole session and asks once for an extra internal reset cycle of fixed length.

Top module: `mon_entry_ctrl`

## Requirements
- R1: While and after power-on reset (`rst_n` low), and before any capture: `mon_mode`=0, `mon_by_hv`=0, `bus_div4`=1, `osc_div_bypass`=0, `wdog_off`=0, `xrst_req`=0.
- R2: If `hv_irq`=1 and `strap`=0 when `seq_done` is sampled high, the block gives `mon_mode`=1, `mon_by_hv`=1, `bus_div4`=0 (divide-by-two) and `osc_div_bypass`=1 from the next cycle.
- R3: If `hv_irq`=1 and `strap`=1 at capture, the block gives `mon_mode`=1, `mon_by_hv`=1, `bus_div4`=1 (divide-by-four) and `osc_div_bypass`=0.
- R4: `bus_clk_en` is high for one cycle in every DIV_LO cycles when `bus_div4`=0, and one in every DIV_HI cycles when `bus_div4`=1. It is never high two cycles in a row.
- R5: If `hv_irq`=0 and `vec_blank`=1 at capture, the block gives `mon_mode`=1, `mon_by_hv`=0, `bus_div4`=1 and `osc_div_bypass`=0, whatever the value of `strap`.
- R6: On the erased-vector route, `xrst_req` goes high in the cycle after capture and stays high for exactly XRST_LEN cycles. It is never raised again before the next power-on reset, even when `seq_done` repeats.
- R7: On the erased-vector route, `wdog_off`=1 for any values of `hv_irq` and `hv_rst`.
- R8: On the high-voltage route, `wdog_off` equals `hv_irq` OR `hv_rst`, in the same cycle.
- R9: After high-voltage entry, raising `hv_rst` and then dropping `hv_irq` keeps `wdog_off`=1 without a break.
- R10: If neither `hv_irq` nor `vec_blank` is set at capture, the block gives `mon_mode`=0, `bus_div4`=1, and `wdog_off`=0 even while `hv_rst`=1.
- R11: Only the first `seq_done` after power-on reset is captured. Later pulses leave `mon_mode`, `mon_by_hv` and `bus_div4` unchanged.
- R12: If `hv_irq`=1 and `vec_blank`=1 together, the high-voltage route is taken and `xrst_req` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (input clock domain) |
| rst_n | input | 1 | Power-on reset, asynchronous active-low |
| seq_done | input | 1 | One-cycle pulse at the end of a reset sequence |
| hv_irq | input | 1 | High voltage detected on the interrupt pin |
| hv_rst | input | 1 | High voltage detected on the reset pin |
| strap | input | 1 | Divisor strap pin level |
| vec_blank | input | 1 | Reset vector reads erased |
| mon_mode | output | 1 | Monitor mode active |
| mon_by_hv | output | 1 | 1 = entered via high voltage, 0 = via erased vector |
| bus_div4 | output | 1 | 1 = divide-by-four, 0 = divide-by-two |
| bus_clk_en | output | 1 | Bus clock enable pulse at the chosen ratio |
| osc_div_bypass | output | 1 | Bypass the oscillator divide-by-two stage |
| wdog_off | output | 1 | Watchdog disable |
| xrst_req | output | 1 | Extra internal reset request |

## Verification
The bench keeps DIV_LO=2 and DIV_HI=4, so a 40-cycle window holds a whole number of periods at either ratio. This makes the pulse count exact. It sets XRST_LEN to 5 rather than the default, so the full extra-reset pulse, and its absence after a second capture pulse, fit in a 20-cycle observation window. The same build covers all eight combinations of interrupt voltage, strap and erased vector, as well as moving the high voltage between pins.

// File: rtl/mon_entry_pkg.sv
package mon_entry_pkg;

  typedef enum logic [1:0] {
    ENTRY_NONE  = 2'd0,
    ENTRY_HV    = 2'd1,
    ENTRY_BLANK = 2'd2
  } entry_e;

  // Route chosen at capture; high voltage on the interrupt pin wins.
  function automatic entry_e pick_entry(input logic hv, input logic blank);
    if (hv)         return ENTRY_HV;
    else if (blank) return ENTRY_BLANK;
    else            return ENTRY_NONE;
  endfunction

endpackage

// File: rtl/mon_entry_latch.sv
module mon_entry_latch
  import mon_entry_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic seq_done,
  input  logic hv_irq,
  input  logic strap,
  input  logic vec_blank,
  output logic mon,
  output logic by_hv,
  output logic div4,
  output logic bypass,
  output logic start_xrst
);

  logic   cap_q, cap_d;
  entry_e ent_q, ent_d;
  logic   strap_q, strap_d;
  logic   take;

  assign take = seq_done && !cap_q;

  always_comb begin
    cap_d   = cap_q;
    ent_d   = ent_q;
    strap_d = strap_q;
    if (take) begin
      cap_d   = 1'b1;
      ent_d   = pick_entry(hv_irq, vec_blank);
      strap_d = strap;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q   <= 1'b0;
      ent_q   <= ENTRY_NONE;
      strap_q <= 1'b0;
    end else if (take) begin
      cap_q   <= cap_d;
      ent_q   <= ent_d;
      strap_q <= strap_d;
    end
  end

  assign start_xrst = take && (pick_entry(hv_irq, vec_blank) == ENTRY_BLANK);
  assign mon        = (ent_q != ENTRY_NONE);
  assign by_hv      = (ent_q == ENTRY_HV);
  assign div4       = !(by_hv && !strap_q);
  assign bypass     = by_hv && !strap_q;

  AST_CAPTURE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    cap_q |=> ($stable(ent_q) && $stable(strap_q))); // R11

  AST_BYPASS_IS_DIV2: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |-> (mon && !div4)); // R2

endmodule

// File: rtl/mon_clk_div.sv
module mon_clk_div #(
  parameter int DIV_LO = 2,
  parameter int DIV_HI = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic div4,
  output logic clk_en
);

  localparam int CW = (DIV_HI > 2) ? $clog2(DIV_HI) : 1;
  localparam logic [CW-1:0] LO_M1 = CW'(DIV_LO - 1);
  localparam logic [CW-1:0] HI_M1 = CW'(DIV_HI - 1);

  logic [CW-1:0] cnt_q, cnt_d, lim;
  logic          en_q, en_d;

  assign lim = div4 ? HI_M1 : LO_M1;

  always_comb begin
    en_d  = (cnt_q >= lim);
    cnt_d = en_d ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      en_q  <= en_d;
    end
  end

  assign clk_en = en_q;

  AST_EN_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> !en_q); // R4

endmodule

// File: rtl/mon_xrst_gen.sv
module mon_xrst_gen #(
  parameter int XRST_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic req
);

  localparam int LW = $clog2(XRST_LEN + 1);

  logic [LW-1:0] cnt_q, cnt_d;
  logic          busy;

  assign busy = (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (start)     cnt_d = LW'(XRST_LEN);
    else if (busy) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (start || busy)  cnt_q <= cnt_d;
  end

  assign req = busy;

  AST_XRST_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> req); // R6

endmodule

// File: rtl/mon_entry_ctrl.sv
module mon_entry_ctrl #(
  parameter int DIV_LO   = 2,
  parameter int DIV_HI   = 4,
  parameter int XRST_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic seq_done,
  input  logic hv_irq,
  input  logic hv_rst,
  input  logic strap,
  input  logic vec_blank,
  output logic mon_mode,
  output logic mon_by_hv,
  output logic bus_div4,
  output logic bus_clk_en,
  output logic osc_div_bypass,
  output logic wdog_off,
  output logic xrst_req
);

  logic [1:0] rsync_q;
  logic       rst_s_n;
  logic       start_xrst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s_n = rsync_q[1];

  mon_entry_latch u_latch (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .seq_done   (seq_done),
    .hv_irq     (hv_irq),
    .strap      (strap),
    .vec_blank  (vec_blank),
    .mon        (mon_mode),
    .by_hv      (mon_by_hv),
    .div4       (bus_div4),
    .bypass     (osc_div_bypass),
    .start_xrst (start_xrst)
  );

  mon_clk_div #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_div (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .div4   (bus_div4),
    .clk_en (bus_clk_en)
  );

  mon_xrst_gen #(.XRST_LEN(XRST_LEN)) u_xrst (
    .clk   (clk),
    .rst_n (rst_s_n),
    .start (start_xrst),
    .req   (xrst_req)
  );

  // Erased-vector session: always off. High-voltage session: held by either pin.
  assign wdog_off = mon_mode && (!mon_by_hv || hv_irq || hv_rst);

  AST_XRST_ONLY_BLANK: assert property (@(posedge clk) disable iff (!rst_s_n)
    xrst_req |-> (mon_mode && !mon_by_hv)); // R6

  AST_WDOG_NORMAL: assert property (@(posedge clk) disable iff (!rst_s_n)
    !mon_mode |-> !wdog_off); // R10

  AST_WDOG_BLANK: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mon_mode && !mon_by_hv) |-> wdog_off); // R7

  AST_HV_DIV2: assert property (@(posedge clk) disable iff (!rst_s_n)
    !bus_div4 |-> (mon_by_hv && osc_div_bypass)); // R2

endmodule

// File: tb/mon_entry_ctrl_tb_top.sv
module mon_entry_ctrl_tb_top;

  localparam int XLEN = 5;

  logic clk = 1'b0;
  logic rst_n, seq_done, hv_irq, hv_rst, strap, vec_blank;
  logic mon_mode, mon_by_hv, bus_div4, bus_clk_en, osc_div_bypass, wdog_off, xrst_req;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  mon_entry_ctrl #(.DIV_LO(2), .DIV_HI(4), .XRST_LEN(XLEN)) dut_i (
    .clk(clk), .rst_n(rst_n), .seq_done(seq_done), .hv_irq(hv_irq),
    .hv_rst(hv_rst), .strap(strap), .vec_blank(vec_blank),
    .mon_mode(mon_mode), .mon_by_hv(mon_by_hv), .bus_div4(bus_div4),
    .bus_clk_en(bus_clk_en), .osc_div_bypass(osc_div_bypass),
    .wdog_off(wdog_off), .xrst_req(xrst_req)
  );

  // {hv_irq, strap, vec_blank} -> {mon, by_hv, div4, bypass, xrst}
  localparam logic [7:0] VEC [8] = '{
    8'b000_00100, 8'b001_10101, 8'b010_00100, 8'b011_10101,
    8'b100_11010, 8'b101_11010, 8'b110_11100, 8'b111_11100
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic por();
    @(negedge clk);
    rst_n = 1'b0; seq_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic capture();
    seq_done = 1'b1;
    @(negedge clk);
    seq_done = 1'b0;
  endtask

  task automatic count_en(output int n);
    n = 0;
    for (int i = 0; i < 40; i++) begin
      n += int'(bus_clk_en);
      @(negedge clk);
    end
  endtask

  task automatic count_xrst(output int n);
    n = 0;
    for (int i = 0; i < 20; i++) begin
      n += int'(xrst_req);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog timeout actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    rst_n = 1'b0; seq_done = 1'b0; hv_irq = 1'b0; hv_rst = 1'b0;
    strap = 1'b0; vec_blank = 1'b0;

    // R1 reset state
    por();
    chk("R1 mon_mode", mon_mode, 0);
    chk("R1 mon_by_hv", mon_by_hv, 0);
    chk("R1 bus_div4", bus_div4, 1);
    chk("R1 bypass", osc_div_bypass, 0);
    chk("R1 wdog_off", wdog_off, 0);
    chk("R1 xrst_req", xrst_req, 0);
    count_en(n);
    chk("R4 default ratio", n, 10);

    // Vector table: R2 R3 R5 R10 R12
    for (int v = 0; v < 8; v++) begin
      por();
      hv_irq = VEC[v][7]; strap = VEC[v][6]; vec_blank = VEC[v][5];
      capture();
      chk("R2 R3 R5 R10 R12 mon_mode", mon_mode, int'(VEC[v][4]));
      chk("R2 R3 R5 R12 mon_by_hv", mon_by_hv, int'(VEC[v][3]));
      chk("R2 R3 R5 R10 bus_div4", bus_div4, int'(VEC[v][2]));
      chk("R2 R3 bypass", osc_div_bypass, int'(VEC[v][1]));
      chk("R6 R12 xrst_req", xrst_req, int'(VEC[v][0]));
      chk("R7 R8 R10 wdog_off", wdog_off, int'(VEC[v][4]));
      hv_irq = 1'b0; strap = 1'b0; vec_blank = 1'b0;
    end

    // R6 R7 R11: erased-vector session
    por();
    vec_blank = 1'b1; strap = 1'b0;
    capture();
    count_xrst(n);
    chk("R6 xrst length", n, XLEN);
    hv_irq = 1'b0; hv_rst = 1'b0;
    #1 chk("R7 wdog no hv", wdog_off, 1);
    hv_rst = 1'b1;
    #1 chk("R7 wdog hv_rst", wdog_off, 1);
    hv_rst = 1'b0;
    @(negedge clk);
    hv_irq = 1'b1; strap = 1'b0;
    capture();
    count_xrst(n);
    chk("R6 no repeat", n, 0);
    chk("R11 by_hv kept", mon_by_hv, 0);
    chk("R11 div4 kept", bus_div4, 1);
    hv_irq = 1'b0; vec_blank = 1'b0;

    // R8 R9: high-voltage session, voltage handed to reset pin
    por();
    hv_irq = 1'b1; strap = 1'b0;
    capture();
    chk("R8 wdog hv_irq", wdog_off, 1);
    count_en(n);
    chk("R4 div2 ratio", n, 20);
    hv_rst = 1'b1;
    #1 chk("R9 both pins", wdog_off, 1);
    hv_irq = 1'b0;
    #1 chk("R9 handed over", wdog_off, 1);
    @(negedge clk);
    hv_rst = 1'b0;
    #1 chk("R8 no hv", wdog_off, 0);
    hv_irq = 1'b1;
    #1 chk("R8 hv_irq back", wdog_off, 1);
    @(negedge clk);
    strap = 1'b1; hv_irq = 1'b0;
    capture();
    chk("R11 div stays 2", bus_div4, 0);
    chk("R11 mon kept", mon_mode, 1);

    // R3 R4 divide-by-four
    por();
    hv_irq = 1'b1; strap = 1'b1;
    capture();
    count_en(n);
    chk("R3 R4 div4 ratio", n, 10);
    hv_irq = 1'b0; strap = 1'b0;

    // R10 normal session ignores reset-pin voltage
    por();
    capture();
    hv_rst = 1'b1;
    #1 chk("R10 wdog stays on", wdog_off, 0);
    chk("R10 mon_mode", mon_mode, 0);
    hv_rst = 1'b0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule